// File: doc/BRIEF.md
# Cascaded Master-Clock Prescaler with Rate Strobes

This block takes one external master clock and divides it through three programmable stages in series. The result is an internal master clock rate. No derived clock is ever generated. Each stage outputs a one-cycle enable in the master-clock domain, and the next stage advances only on that enable. The overall division is the product of the three selected stage ratios. The first two stages choose from pass-through, /2 and /3. The last stage chooses from pass-through, /2 and /4.

From the internal-clock enable, the block forms three further enables:
- a DAC modulator enable on every second internal tick;
- an ADC modulator enable on every fourth internal tick;
- a sample strobe on every 256th internal tick, or every 128th when the low-latency mode bit is set.

As an example, selecting /3, /2 and pass-through turns 12.288 MHz into 2.048 MHz, which gives an 8 kHz sample rate. Selecting pass-through, pass-through and /4 turns 11.2896 MHz into 2.8224 MHz, which gives 11.025 kHz.

A two-state sequencer (HOLD, RUN) keeps every counter cleared while reset is applied and whenever the configuration changes. The next period therefore always starts from zero, and no short or glitched period can appear.

Top module: `mclk_prescale_gen`

## Requirements
- R1: Stage one and stage two select their ratio with a 2-bit code: 2'b00 is /1, 2'b01 is /2, 2'b10 is /3, and 2'b11 is /1.
- R2: Stage three decodes its 2-bit code as follows: 2'b00 is /1, 2'b01 is /2, 2'b10 is /4, and 2'b11 is /1.
- R3: P is the product of the three stage ratios. Counting RUN cycles from 1, `imclk_en` is high in cycle c exactly when c mod P is 0.
- R4: `dac_mod_en` is high exactly on every 2nd `imclk_en` pulse (pulses 2, 4, 6, ... since the restart).
- R5: `adc_mod_en` is high exactly on every 4th `imclk_en` pulse.
- R6: With `low_delay` = 0, `fs_strobe` is high exactly on every 256th `imclk_en` pulse.
- R7: With `low_delay` = 1, `fs_strobe` is high exactly on every 128th `imclk_en` pulse.
- R8: `rst` is synchronous and active high. All outputs stay low while it is applied and in the first cycle after it is released (the HOLD state). RUN cycle 1 is the cycle after that.
- R9: Suppose any select code or `low_delay` differs from its value at the previous clock edge. Then all outputs are low in that cycle and in the next one (HOLD), and counting restarts at RUN cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External master clock |
| rst | input | 1 | Synchronous reset, active high |
| stage1_sel | input | 2 | Ratio code of the first stage |
| stage2_sel | input | 2 | Ratio code of the second stage |
| stage3_sel | input | 2 | Ratio code of the third stage |
| low_delay | input | 1 | Shortened sample period (128 internal ticks) |
| imclk_en | output | 1 | Internal master clock enable |
| dac_mod_en | output | 1 | DAC modulator enable |
| adc_mod_en | output | 1 | ADC modulator enable |
| fs_strobe | output | 1 | Sample-rate strobe |

## Verification
Every cycle, the bench compares all four enables with a model built only from the run-cycle count and the product of the decoded ratios.

The directed settings are chosen to isolate faults:
- All pass-through separates the tick-count logic from the stage chain.
- The /6 and /4 settings confirm that odd and power-of-two stages compose by product.
- The spare codes and the /36 maximum expose decode and counter-width faults.

Configuration changes and resets are applied in the middle of periods. This reveals any counter that fails to restart.

A fixed-seed random series of settings in both modes then covers combinations the directed cases miss.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

    localparam int unsigned NUM_STAGES = 3;
    localparam int unsigned SEL_W      = 2;

    // Ratio reached by code 2'b01 and code 2'b10 in each stage.
    localparam int unsigned STAGE_LOW_RATIO  [NUM_STAGES] = '{2, 2, 2};
    localparam int unsigned STAGE_HIGH_RATIO [NUM_STAGES] = '{3, 3, 4};

    typedef enum logic [SEL_W-1:0] {
        SEL_THRU  = 2'b00,
        SEL_LOW   = 2'b01,
        SEL_HIGH  = 2'b10,
        SEL_SPARE = 2'b11
    } sel_code_e;

    typedef struct packed {
        logic [NUM_STAGES-1:0][SEL_W-1:0] sel;
        logic                             low_delay;
    } rate_cfg_t;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/pscl_seq.sv
module pscl_seq
    import pscl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rate_cfg_t cfg_i,
    output logic      run_o
);

    seq_state_e state_q;
    seq_state_e state_d;
    rate_cfg_t  cfg_q;
    logic       cfg_moved;

    assign cfg_moved = (cfg_i != cfg_q);

    // State register and configuration snapshot
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
        cfg_q <= cfg_i;
    end

    // Transitions: HOLD -> RUN once the setting is steady,
    // RUN -> HOLD as soon as the setting moves.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: if (!cfg_moved) state_d = ST_RUN;
            ST_RUN:  if (cfg_moved)  state_d = ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_RUN:  run_o = !cfg_moved && !rst;
            default: run_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pscl_stage.sv
module pscl_stage
    import pscl_pkg::*;
#(
    parameter int unsigned LOW_RATIO  = 2,
    parameter int unsigned HIGH_RATIO = 3
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             adv_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             adv_o
);

    localparam int unsigned MAX_RATIO = (HIGH_RATIO > LOW_RATIO) ? HIGH_RATIO : LOW_RATIO;
    localparam int unsigned CW        = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;
    logic          wrap;

    always_comb begin
        unique case (sel_code_e'(sel_i))
            SEL_LOW:  last = CW'(LOW_RATIO - 1);
            SEL_HIGH: last = CW'(HIGH_RATIO - 1);
            default:  last = '0;
        endcase
    end

    assign wrap  = (cnt_q == last);
    assign adv_o = adv_i && wrap;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= wrap ? '0 : cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/pscl_rate.sv
module pscl_rate #(
    parameter int unsigned DAC_DIV   = 2,
    parameter int unsigned ADC_DIV   = 4,
    parameter int unsigned FS_NORMAL = 256,
    parameter int unsigned FS_SHORT  = 128
) (
    input  logic clk,
    input  logic clr,
    input  logic tick_i,
    input  logic low_delay_i,
    output logic dac_o,
    output logic adc_o,
    output logic fs_o
);

    // All divisors are powers of two that divide FS_NORMAL.
    localparam int unsigned CW = $clog2(FS_NORMAL);
    localparam logic [CW-1:0] DAC_MASK  = CW'(DAC_DIV - 1);
    localparam logic [CW-1:0] ADC_MASK  = CW'(ADC_DIV - 1);
    localparam logic [CW-1:0] NORM_MASK = CW'(FS_NORMAL - 1);
    localparam logic [CW-1:0] SHRT_MASK = CW'(FS_SHORT - 1);

    logic [CW-1:0] tick_q;
    logic [CW-1:0] fs_mask;

    assign fs_mask = low_delay_i ? SHRT_MASK : NORM_MASK;
    assign dac_o   = tick_i && ((tick_q & DAC_MASK) == DAC_MASK);
    assign adc_o   = tick_i && ((tick_q & ADC_MASK) == ADC_MASK);
    assign fs_o    = tick_i && ((tick_q & fs_mask) == fs_mask);

    always_ff @(posedge clk) begin
        if (clr) begin
            tick_q <= '0;
        end else if (tick_i) begin
            tick_q <= tick_q + CW'(1);
        end
    end

endmodule

// File: rtl/mclk_prescale_gen.sv
module mclk_prescale_gen
    import pscl_pkg::*;
#(
    parameter int unsigned DAC_DIV   = 2,
    parameter int unsigned ADC_DIV   = 4,
    parameter int unsigned FS_NORMAL = 256,
    parameter int unsigned FS_SHORT  = 128
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] stage1_sel,
    input  logic [1:0] stage2_sel,
    input  logic [1:0] stage3_sel,
    input  logic       low_delay,
    output logic       imclk_en,
    output logic       dac_mod_en,
    output logic       adc_mod_en,
    output logic       fs_strobe
);

    rate_cfg_t             cfg;
    logic                  run;
    logic                  clr;
    logic [NUM_STAGES:0]   link;

    assign cfg.sel[0]    = stage1_sel;
    assign cfg.sel[1]    = stage2_sel;
    assign cfg.sel[2]    = stage3_sel;
    assign cfg.low_delay = low_delay;

    pscl_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .cfg_i (cfg),
        .run_o (run)
    );

    assign clr     = !run;
    assign link[0] = run;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        pscl_stage #(
            .LOW_RATIO  (STAGE_LOW_RATIO[g]),
            .HIGH_RATIO (STAGE_HIGH_RATIO[g])
        ) u_stage (
            .clk   (clk),
            .clr   (clr),
            .adv_i (link[g]),
            .sel_i (cfg.sel[g]),
            .adv_o (link[g+1])
        );
    end

    assign imclk_en = link[NUM_STAGES];

    pscl_rate #(
        .DAC_DIV   (DAC_DIV),
        .ADC_DIV   (ADC_DIV),
        .FS_NORMAL (FS_NORMAL),
        .FS_SHORT  (FS_SHORT)
    ) u_rate (
        .clk         (clk),
        .clr         (clr),
        .tick_i      (imclk_en),
        .low_delay_i (low_delay),
        .dac_o       (dac_mod_en),
        .adc_o       (adc_mod_en),
        .fs_o        (fs_strobe)
    );

endmodule

// File: rtl/mclk_prescale_gen_chk.sv
module mclk_prescale_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] stage1_sel,
    input logic [1:0] stage2_sel,
    input logic [1:0] stage3_sel,
    input logic       low_delay,
    input logic       imclk_en,
    input logic       dac_mod_en,
    input logic       adc_mod_en,
    input logic       fs_strobe
);

    logic [6:0] cfg_now;
    logic [6:0] cfg_prev;
    logic       moved_q;

    assign cfg_now = {stage1_sel, stage2_sel, stage3_sel, low_delay};

    always_ff @(posedge clk) begin
        cfg_prev <= cfg_now;
        moved_q  <= rst ? 1'b0 : (cfg_now != cfg_prev);
    end

    AST_DAC_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        dac_mod_en |-> imclk_en); // R4
    AST_ADC_WITH_DAC: assert property (@(posedge clk) disable iff (rst)
        adc_mod_en |-> (dac_mod_en && imclk_en)); // R5
    AST_FS_WITH_ADC: assert property (@(posedge clk) disable iff (rst)
        fs_strobe |-> adc_mod_en); // R6
    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(imclk_en || dac_mod_en || adc_mod_en || fs_strobe)); // R8
    AST_CHANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cfg_now != $past(cfg_now)) |-> !imclk_en); // R9
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        moved_q |-> !imclk_en); // R9

endmodule

bind mclk_prescale_gen mclk_prescale_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .stage1_sel (stage1_sel),
    .stage2_sel (stage2_sel),
    .stage3_sel (stage3_sel),
    .low_delay  (low_delay),
    .imclk_en   (imclk_en),
    .dac_mod_en (dac_mod_en),
    .adc_mod_en (adc_mod_en),
    .fs_strobe  (fs_strobe)
);

// File: tb/mclk_prescale_gen_test.sv
module mclk_prescale_gen_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] s1, s2, s3;
    logic       ld;
    logic       imclk_en, dac_mod_en, adc_mod_en, fs_strobe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mclk_prescale_gen uut (
        .clk        (clk),
        .rst        (rst),
        .stage1_sel (s1),
        .stage2_sel (s2),
        .stage3_sel (s3),
        .low_delay  (ld),
        .imclk_en   (imclk_en),
        .dac_mod_en (dac_mod_en),
        .adc_mod_en (adc_mod_en),
        .fs_strobe  (fs_strobe)
    );

    function automatic int ratio_ab(input logic [1:0] c); // R1
        case (c)
            2'b01:   return 2;
            2'b10:   return 3;
            default: return 1;
        endcase
    endfunction

    function automatic int ratio_c(input logic [1:0] c); // R2
        case (c)
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    task automatic chk_dead(input string req);
        chk(req, "imclk_en",   imclk_en,   1'b0);
        chk(req, "dac_mod_en", dac_mod_en, 1'b0);
        chk(req, "adc_mod_en", adc_mod_en, 1'b0);
        chk(req, "fs_strobe",  fs_strobe,  1'b0);
    endtask

    // Runs n RUN cycles counted from the last restart; ick_req tags the tick check.
    task automatic run(input int n, input string ick_req);
        int p;
        int per;
        p   = ratio_ab(s1) * ratio_ab(s2) * ratio_c(s3);
        per = ld ? 128 : 256;
        for (int c = 1; c <= n; c++) begin
            logic e_ick, e_dac, e_adc, e_fs;
            int k;
            @(negedge clk); #1;
            e_ick = (c % p) == 0;
            k     = c / p;
            e_dac = e_ick && (k % 2 == 0);
            e_adc = e_ick && (k % 4 == 0);
            e_fs  = e_ick && (k % per == 0);
            chk(ick_req, "imclk_en", imclk_en, e_ick);
            chk("R4", "dac_mod_en", dac_mod_en, e_dac);
            chk("R5", "adc_mod_en", adc_mod_en, e_adc);
            chk(ld ? "R7" : "R6", "fs_strobe", fs_strobe, e_fs);
        end
    endtask

    task automatic set_cfg(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c, input logic l);
        @(negedge clk);
        s1 = a; s2 = b; s3 = c; ld = l;
        #1 chk_dead("R9");
        @(negedge clk); #1 chk_dead("R9");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk); #1 chk_dead("R8");
        end
        @(negedge clk);
        rst = 1'b0;
        #1 chk_dead("R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; s1 = 2'b00; s2 = 2'b00; s3 = 2'b00; ld = 1'b0;
        void'($urandom(32'h1F2E3D4C));
        repeat (2) @(negedge clk);

        do_reset();                        // R8
        run(600, "R3");                    // pass-through everywhere, R6
        set_cfg(2'b00, 2'b00, 2'b00, 1'b1);
        run(300, "R3");                    // R7
        set_cfg(2'b10, 2'b01, 2'b00, 1'b0);
        run(6 * 256 + 12, "R1");           // /3 * /2 = 6
        set_cfg(2'b00, 2'b00, 2'b10, 1'b0);
        run(4 * 256 + 8, "R2");            // /4 in stage three
        set_cfg(2'b11, 2'b11, 2'b11, 1'b1);
        run(140, "R1");                    // spare codes pass through
        set_cfg(2'b10, 2'b10, 2'b10, 1'b1);
        run(36 * 128 + 40, "R2");          // maximum ratio 36
        set_cfg(2'b01, 2'b00, 2'b01, 1'b0);
        run(50, "R3");
        set_cfg(2'b01, 2'b00, 2'b01, 1'b1); // mode-only change mid period
        run(4 * 128 + 20, "R9");
        run(0, "R3");
        do_reset();                        // reset mid period
        run(4 * 256 + 10, "R8");

        for (int i = 0; i < 8; i++) begin
            logic [1:0] a, b, c;
            logic       l;
            int         p;
            a = 2'($urandom % 4);
            b = 2'($urandom % 4);
            c = 2'($urandom % 4);
            l = 1'($urandom % 2);
            if ({a, b, c, l} == {s1, s2, s3, ld}) l = ~l;
            set_cfg(a, b, c, l);
            p = ratio_ab(a) * ratio_ab(b) * ratio_c(c);
            run(p * (l ? 130 : 258), "R3");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule